// File: doc/BRIEF.md
# Asymmetric Duty Lamp Flash Timer

This block produces a single dark flag shared by the hazard and turn-indicator lamps so that all of them flash together at one rate and one duty cycle. Its enable input is expected to be the OR of the hazard, left and right indicator states. While the enable is high, the block alternates between a lit phase and a shorter dark phase. Both phases are counted in ticks of a slow timebase strobe: by default 16 ticks lit and 8 ticks dark, which is about one half and one quarter of a second at 32 Hz and gives roughly a two-thirds duty cycle.

The dark flag serves as a mask over every flashing lamp. While the flag is set, downstream logic forces those lamps to their off level. When the enable is low, the timer holds a fixed restart state, with the flag set and the counter loaded with the lit length. Every activation therefore begins with a complete lit phase, whatever point the previous activation had reached when it stopped. Choosing which lamps flash is left to the surrounding logic.

Top module: `flash_dark_timer`

## Requirements
- R1: While reset is asserted, and after it is released, `dark` reads 1 until the first enabled clock edge.
- R2: After any clock edge at which `enable` is sampled low, `dark` reads 1 and the timer returns to its restart state.
- R3: At the first clock edge at which `enable` is sampled high after being low (or after reset), `dark` goes to 0. A `tick` sampled at that same edge is not counted.
- R4: A lit phase spans exactly LIGHT_TICKS (default 16) counted ticks. `dark` rises at the edge that samples the last of those ticks.
- R5: A dark phase that follows a lit phase spans exactly DARK_TICKS (default 8) counted ticks, after which a new lit phase of LIGHT_TICKS ticks begins. The two phases keep alternating while `enable` stays high.
- R6: A `tick` sampled while `enable` is low has no effect: `dark` stays 1 and the next activation still lights for the full LIGHT_TICKS.
- R7: While running, an edge with `tick` low leaves `dark` and the remaining count unchanged, so the phase lengths depend only on the number of ticks and not on how far apart they are.
- R8: When `enable` drops part way through either phase and is raised again, the new activation starts with a full lit phase of LIGHT_TICKS ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | High while any flashing source (hazard, left or right) is active |
| tick | input | 1 | Single-cycle strobe from the slow timebase |
| dark | output | 1 | 1 = flashing lamps forced off, 0 = lit phase |

## Verification
The assertions take for granted that `tick` is a strobe sampled at the clock edge, with no relation to `enable`, and that `enable` can change at any edge, including in the middle of a phase or on the same edge as a tick. They also assume that the two phase lengths are at least one tick. The stimulus changes `enable` and `tick` only at falling clock edges and covers dense ticks, sparse and irregular ticks, ticks while disabled, and an activation that coincides with a tick. It also drops `enable` in the middle of both the lit and the dark phase, so that every input combination the properties reason about actually occurs.

// File: rtl/flash_pkg.sv
package flash_pkg;
  // Width needed to hold the longer of the two phase lengths.
  function automatic int unsigned count_width(int unsigned light_t, int unsigned dark_t);
    int unsigned m;
    m = (light_t > dark_t) ? light_t : dark_t;
    return (m < 2) ? 1 : $clog2(m + 1);
  endfunction

  // Number of ticks for the phase being entered.
  function automatic int unsigned phase_length(logic entering_dark,
                                               int unsigned light_t,
                                               int unsigned dark_t);
    return entering_dark ? dark_t : light_t;
  endfunction
endpackage

// File: rtl/flash_tick_counter.sv
module flash_tick_counter #(
  parameter int unsigned LIGHT_TICKS = 16,
  parameter int unsigned DARK_TICKS  = 8,
  parameter int unsigned CNT_W       = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             advance,
  input  logic             to_dark,
  output logic [CNT_W-1:0] count,
  output logic             expire
);
  localparam int unsigned MAXT = (LIGHT_TICKS > DARK_TICKS) ? LIGHT_TICKS : DARK_TICKS;
  localparam logic [CNT_W-1:0] LIGHT_LOAD = CNT_W'(LIGHT_TICKS);

  logic [CNT_W-1:0] reload;
  assign reload = CNT_W'(flash_pkg::phase_length(to_dark, LIGHT_TICKS, DARK_TICKS));
  assign expire = advance && (count == CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          count <= LIGHT_LOAD;
    else if (restart)    count <= LIGHT_LOAD;
    else if (expire)     count <= reload;
    else if (advance)    count <= count - CNT_W'(1);
  end

  // R4: the remaining count never leaves 1..max phase length
  assert_count_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (count >= CNT_W'(1)) && (count <= CNT_W'(MAXT)));
  // R5: an expiry loads the length of the phase being entered
  assert_reload_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !restart) |=> (count == $past(reload)));
  // R7: no tick, no restart: count is frozen
  assert_count_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!advance && !restart) |=> $stable(count));
endmodule

// File: rtl/flash_phase_ctl.sv
module flash_phase_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic expire,
  output logic dark,
  output logic running
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dark    <= 1'b1;
      running <= 1'b0;
    end else if (!enable) begin
      dark    <= 1'b1;
      running <= 1'b0;
    end else if (!running) begin
      dark    <= 1'b0;
      running <= 1'b1;
    end else if (expire) begin
      dark    <= ~dark;
    end
  end

  // R2: disabled edge forces the mask on
  assert_idle_dark_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (dark && !running));
  // R3: activation begins lit
  assert_start_lit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !running) |=> (!dark && running));
  // R5: an expiry while running inverts the phase
  assert_flip_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && running && expire) |=> (dark != $past(dark)));
  // R7: running without expiry holds the phase
  assert_phase_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && running && !expire) |=> $stable(dark));
endmodule

// File: rtl/flash_dark_timer.sv
module flash_dark_timer #(
  parameter int unsigned LIGHT_TICKS = 16,
  parameter int unsigned DARK_TICKS  = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic tick,
  output logic dark
);
  localparam int unsigned CNT_W = flash_pkg::count_width(LIGHT_TICKS, DARK_TICKS);

  logic             running;
  logic             restart_w;
  logic             advance_w;
  logic             expire_w;
  logic             to_dark_w;
  logic [CNT_W-1:0] count_w;

  assign restart_w = !enable || !running;
  assign advance_w = enable && running && tick;
  assign to_dark_w = !dark;

  flash_tick_counter #(
    .LIGHT_TICKS(LIGHT_TICKS),
    .DARK_TICKS (DARK_TICKS),
    .CNT_W      (CNT_W)
  ) cnt_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .restart(restart_w),
    .advance(advance_w),
    .to_dark(to_dark_w),
    .count  (count_w),
    .expire (expire_w)
  );

  flash_phase_ctl phase_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .enable (enable),
    .expire (expire_w),
    .dark   (dark),
    .running(running)
  );

  // R1/R8: an idle timer always sits at the full lit length
  assert_idle_reload_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> (count_w == CNT_W'(LIGHT_TICKS)));
  // R6: ticks while disabled keep the mask set
  assert_tick_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable && tick) |=> dark);
endmodule

// File: tb/flash_dark_timer_tb_top.sv
module flash_dark_timer_tb_top;
  localparam int L = 16;
  localparam int D = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0;
  logic tick = 1'b0;
  logic dark;

  int checks = 0;
  int errors = 0;
  string cur_req = "R1";
  bit done = 1'b0;

  // behavioural reference
  int m_dark = 1;
  int m_run = 0;
  int m_left = L;

  always #4 clk = ~clk;

  flash_dark_timer #(.LIGHT_TICKS(L), .DARK_TICKS(D)) dut_i (
    .clk(clk), .rst_n(rst_n), .enable(enable), .tick(tick), .dark(dark));

  always @(posedge clk) begin
    if (!rst_n || !enable) begin
      m_dark = 1; m_run = 0; m_left = L;
    end else if (m_run == 0) begin
      m_run = 1; m_dark = 0; m_left = L;
    end else if (tick) begin
      if (m_left == 1) begin
        m_dark = 1 - m_dark;
        m_left = (m_dark == 1) ? D : L;
      end else m_left = m_left - 1;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // every-cycle comparison against the model
  always @(negedge clk) begin
    if (!done) check(int'(dark) == m_dark, cur_req, int'(dark), m_dark);
  end

  task automatic cyc(input bit en, input bit tk);
    @(negedge clk);
    enable = en; tick = tk;
  endtask

  // apply dense ticks until dark is seen; returns ticks applied
  task automatic ticks_until(input bit want_dark, output int n);
    n = 0;
    while (int'(dark) != int'(want_dark) && n < 100) begin
      cyc(1'b1, 1'b1);
      n++;
      @(posedge clk); #1;
    end
  endtask

  initial begin : watchdog
    #1000000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int n;
    int lfsr;
    cur_req = "R1";
    repeat (3) @(negedge clk);
    check(dark == 1'b1, "R1", int'(dark), 1);
    rst_n = 1'b1;
    repeat (3) cyc(1'b0, 1'b0);
    check(dark == 1'b1, "R1", int'(dark), 1);

    // R6: ticks with enable low
    cur_req = "R6";
    repeat (10) cyc(1'b0, 1'b1);
    @(posedge clk); #1;
    check(dark == 1'b1, "R6", int'(dark), 1);

    // R3: activation edge coinciding with a tick
    cur_req = "R3";
    cyc(1'b1, 1'b1);
    @(posedge clk); #1;
    check(dark == 1'b0, "R3", int'(dark), 0);
    cyc(1'b1, 1'b0);
    @(posedge clk); #1;

    // R4 / R5 dense ticks
    cur_req = "R4";
    ticks_until(1'b1, n);
    check(n == L, "R4", n, L);
    cur_req = "R5";
    ticks_until(1'b0, n);
    check(n == D, "R5", n, D);
    cur_req = "R4";
    ticks_until(1'b1, n);
    check(n == L, "R4", n, L);

    // R7: sparse irregular ticks, model compared each cycle
    cur_req = "R7";
    lfsr = 8'h5a;
    for (int i = 0; i < 400; i++) begin
      lfsr = ((lfsr << 1) | (((lfsr >> 7) ^ (lfsr >> 5) ^ (lfsr >> 4) ^ (lfsr >> 3)) & 1)) & 8'hff;
      cyc(1'b1, lfsr[0] & lfsr[3]);
    end
    cyc(1'b1, 1'b0);
    @(posedge clk); #1;
    n = int'(dark);
    repeat (5) cyc(1'b1, 1'b0);
    @(posedge clk); #1;
    check(int'(dark) == n, "R7", int'(dark), n);

    // R8: drop mid-dark and re-enable
    cur_req = "R8";
    cyc(1'b0, 1'b0); cyc(1'b1, 1'b0);
    @(posedge clk); #1;
    ticks_until(1'b1, n);
    repeat (3) cyc(1'b1, 1'b1);
    cyc(1'b0, 1'b0);
    @(posedge clk); #1;
    check(dark == 1'b1, "R2", int'(dark), 1);
    cyc(1'b1, 1'b0);
    @(posedge clk); #1;
    check(dark == 1'b0, "R8", int'(dark), 0);
    ticks_until(1'b1, n);
    check(n == L, "R8", n, L);

    // R8: drop mid-light and re-enable
    cyc(1'b1, 1'b0); cyc(1'b0, 1'b0); cyc(1'b1, 1'b0);
    @(posedge clk); #1;
    repeat (5) cyc(1'b1, 1'b1);
    cur_req = "R2";
    cyc(1'b0, 1'b1);
    @(posedge clk); #1;
    check(dark == 1'b1, "R2", int'(dark), 1);
    cur_req = "R8";
    cyc(1'b1, 1'b0);
    @(posedge clk); #1;
    ticks_until(1'b1, n);
    check(n == L, "R8", n, L);
    cur_req = "R5";
    ticks_until(1'b0, n);
    check(n == D, "R5", n, D);

    cyc(1'b0, 1'b0);
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule